// File: doc/BRIEF.md
# Serial Coding Path Controller

This block carries a serial transmit bit stream through two optional coding stages: a byte-latency outer encoder and a pseudo-random scrambler. Configuration inputs set the order of the two stages and whether the outer encoder and its byte-wide alignment delay are in the path at all. They also give each function a two-bit mode field. A field can force the function off, force it on, or hand control to a level input. For the advance function that input is the data-enable strobe. For each coding stage it is a dedicated pin, which is synchronised into the clock domain before use.

The block runs on the bit clock. In any cycle where the advance function is active, one input bit is taken in, every stage moves by one bit, and the registered serial output updates. In all other cycles the whole path holds. A coding stage is switched between on and bypass only at a byte boundary, so the output stream stays aligned to bytes.

The coding stages are placeholders:
- The scrambler XORs the stream with a 7-bit maximal-length sequence.
- The outer encoder delays the stream by one byte and, when it is on, inverts it.

Top module: `serial_coding_path`

## Requirements
- R1: After reset, `sdata_out` is 0, the bit counter is at the start of a byte, and both coding stages are in bypass.
- R2: The advance mode field `cfg_adv_mode` works as follows. Value 01 holds the path: there are no strobes and `sdata_out` does not change. Value 11 advances every cycle. Any value with bit 0 clear advances in the cycle after the one in which `data_en` was sampled high, which is a one-register internal delay.
- R3: Each coding stage mode field works as follows. Value 01 requests bypass and 11 requests on. Any value with bit 0 clear requests the level of that stage's pin, taken through a two-flop synchroniser, with high meaning on.
- R4: A stage's effective on/bypass state takes its requested value only on the advance step that completes a byte, which is every eighth step counted from reset. At all other times the state is held.
- R5: The scrambler is a Fibonacci LFSR with 7 bits, a tap mask of 7'b1100000 and a seed of all ones. On every advance step it shifts left and feeds in the XOR of the tapped bits, whether the scrambler is on or not. When the scrambler is on, it XORs the stream with state bit 6 as that bit stands before the shift.
- R6: With `cfg_enc_path` = 1, the outer encoder emits the bit that entered it eight advance steps earlier, inverted when the encoder is on. Its delay line starts at zero after reset.
- R7: With `cfg_enc_path` = 1, `cfg_scr_first` = 1 scrambles before the encoder. With `cfg_enc_path` = 1, `cfg_scr_first` = 0 scrambles the encoder's output.
- R8: With `cfg_enc_path` = 0, the encoder and its delay are out of the path, so the scrambler output is registered directly. In that case `cfg_scr_first` and the encoder mode have no effect, and the delay line does not shift.
- R9: `scr_step` is high exactly in advance cycles. `enc_step` is high in advance cycles while `cfg_enc_path` = 1. `sdata_out` changes only on the clock edge that ends an advance cycle.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Bit clock |
| rst_n | input | 1 | Asynchronous active-low reset, released synchronously inside |
| sdata_in | input | 1 | Serial input bit, taken in advance cycles |
| data_en | input | 1 | Data-enable strobe, used when the advance mode hands control to it |
| pin_scr | input | 1 | External scrambler enable level |
| pin_enc | input | 1 | External outer-encoder enable level |
| cfg_adv_mode | input | 2 | Advance mode: 01 hold, 11 always, bit 0 clear follows data_en |
| cfg_scr_mode | input | 2 | Scrambler mode: 01 bypass, 11 on, bit 0 clear follows pin_scr |
| cfg_enc_mode | input | 2 | Encoder mode: 01 bypass, 11 on, bit 0 clear follows pin_enc |
| cfg_scr_first | input | 1 | 1 scrambler then encoder, 0 encoder then scrambler |
| cfg_enc_path | input | 1 | 1 encoder and byte delay in path, 0 removed |
| sdata_out | output | 1 | Registered encoded serial output |
| scr_step | output | 1 | Advance strobe to the scrambler stage |
| enc_step | output | 1 | Advance strobe to the outer-encoder stage |

## Verification
The bench builds the block with its default parameters: a 7-bit scrambler sequence and an 8-bit byte. These are small enough for a bench model to track the sequence, the bit count and the whole delay line exactly. The bench sweeps all combinations of the three mode fields (hold, forced on, pin-controlled), both stage orders and both path settings. In pin-controlled modes it toggles the pins at periods that do not divide the byte length. This puts pin changes at every position within a byte, which tests the byte-boundary rule and the synchroniser delay. Each run spans several bytes, so the delayed encoder output and the sequence state after many steps both come under test.

// File: rtl/scp_pkg.sv
package scp_pkg;
  localparam logic [1:0] MODE_OFF = 2'b01;
  localparam logic [1:0] MODE_ON  = 2'b11;

  // Mode fields: bit 0 set means forced, bit 1 then gives the level;
  // bit 0 clear means the external level decides.
  function automatic logic mode_resolve(input logic [1:0] mode, input logic ext);
    return mode[0] ? mode[1] : ext;
  endfunction
endpackage

// File: rtl/scp_rst_sync.sv
module scp_rst_sync (
  input  logic clk,
  input  logic rst_n,
  output logic rst_n_sync
);
  logic stage_q;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      stage_q    <= 1'b0;
      rst_n_sync <= 1'b0;
    end else begin
      stage_q    <= 1'b1;
      rst_n_sync <= stage_q;
    end
  end
endmodule

// File: rtl/scp_sync.sv
module scp_sync #(
  parameter int N = 2
) (
  input  logic         clk,
  input  logic         rst_n,
  input  logic [N-1:0] d,
  output logic [N-1:0] q
);
  for (genvar i = 0; i < N; i++) begin : g_bit
    logic meta_q;
    logic out_q;
    always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
        meta_q <= 1'b0;
        out_q  <= 1'b0;
      end else begin
        meta_q <= d[i];
        out_q  <= meta_q;
      end
    end
    assign q[i] = out_q;
  end
endmodule

// File: rtl/scp_lfsr.sv
module scp_lfsr #(
  parameter int              W    = 7,
  parameter logic [W-1:0]    TAPS = 7'b1100000,
  parameter logic [W-1:0]    SEED = '1
) (
  input  logic clk,
  input  logic rst_n,
  input  logic en,
  output logic pn_bit
);
  logic [W-1:0] state_q, state_d;

  always_comb begin
    state_d = state_q;
    if (en) state_d = {state_q[W-2:0], ^(state_q & TAPS)};
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) state_q <= SEED;
    else        state_q <= state_d;
  end

  assign pn_bit = state_q[W-1];

  // R5
  lfsr_nonzero_chk: assert property (@(posedge clk) disable iff (!rst_n)
    state_q != '0);
  // R5
  lfsr_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
    !en |=> $stable(state_q));
endmodule

// File: rtl/scp_delay.sv
module scp_delay #(
  parameter int DEPTH = 8
) (
  input  logic clk,
  input  logic rst_n,
  input  logic en,
  input  logic din,
  output logic dout
);
  logic [DEPTH-1:0] line_q, line_d;

  always_comb begin
    line_d = line_q;
    if (en) line_d = {line_q[DEPTH-2:0], din};
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) line_q <= '0;
    else        line_q <= line_d;
  end

  assign dout = line_q[DEPTH-1];

  // R8
  delay_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
    !en |=> $stable(line_q));
endmodule

// File: rtl/serial_coding_path.sv
module serial_coding_path #(
  parameter int           BYTE_BITS = 8,
  parameter int           PN_W      = 7,
  parameter logic [PN_W-1:0] PN_TAPS = 7'b1100000
) (
  input  logic       clk,
  input  logic       rst_n,
  input  logic       sdata_in,
  input  logic       data_en,
  input  logic       pin_scr,
  input  logic       pin_enc,
  input  logic [1:0] cfg_adv_mode,
  input  logic [1:0] cfg_scr_mode,
  input  logic [1:0] cfg_enc_mode,
  input  logic       cfg_scr_first,
  input  logic       cfg_enc_path,
  output logic       sdata_out,
  output logic       scr_step,
  output logic       enc_step
);
  import scp_pkg::*;

  localparam int CNT_W = (BYTE_BITS > 1) ? $clog2(BYTE_BITS) : 1;
  localparam logic [CNT_W-1:0] LAST_BIT = CNT_W'(BYTE_BITS - 1);

  logic rst_n_i;
  logic [1:0] pin_s;
  logic de_q;
  logic step, boundary;
  logic [CNT_W-1:0] cnt_q, cnt_d;
  logic scr_on_q, scr_on_d, enc_on_q, enc_on_d;
  logic out_q, out_d;
  logic pn_bit, scr_mask;
  logic enc_in, enc_dly, enc_out;

  scp_rst_sync u_rst (.clk(clk), .rst_n(rst_n), .rst_n_sync(rst_n_i));

  scp_sync #(.N(2)) u_pin_sync (
    .clk(clk), .rst_n(rst_n_i), .d({pin_enc, pin_scr}), .q(pin_s)
  );

  // Internal one-register delay on the data-enable strobe.
  always_ff @(posedge clk or negedge rst_n_i) begin
    if (!rst_n_i) de_q <= 1'b0;
    else          de_q <= data_en;
  end

  assign step     = mode_resolve(cfg_adv_mode, de_q);
  assign boundary = step && (cnt_q == LAST_BIT);
  assign scr_step = step;
  assign enc_step = step & cfg_enc_path;

  // Next-state: bit counter and byte-aligned stage enables.
  always_comb begin
    cnt_d    = cnt_q;
    scr_on_d = scr_on_q;
    enc_on_d = enc_on_q;
    if (step) cnt_d = boundary ? '0 : cnt_q + 1'b1;
    if (boundary) begin
      scr_on_d = mode_resolve(cfg_scr_mode, pin_s[0]);
      enc_on_d = mode_resolve(cfg_enc_mode, pin_s[1]);
    end
  end

  always_ff @(posedge clk or negedge rst_n_i) begin
    if (!rst_n_i) begin
      cnt_q    <= '0;
      scr_on_q <= 1'b0;
      enc_on_q <= 1'b0;
    end else begin
      cnt_q    <= cnt_d;
      scr_on_q <= scr_on_d;
      enc_on_q <= enc_on_d;
    end
  end

  scp_lfsr #(.W(PN_W), .TAPS(PN_TAPS), .SEED('1)) u_scr (
    .clk(clk), .rst_n(rst_n_i), .en(scr_step), .pn_bit(pn_bit)
  );

  assign scr_mask = scr_on_q & pn_bit;
  assign enc_in   = cfg_scr_first ? (sdata_in ^ scr_mask) : sdata_in;

  scp_delay #(.DEPTH(BYTE_BITS)) u_enc (
    .clk(clk), .rst_n(rst_n_i), .en(enc_step), .din(enc_in), .dout(enc_dly)
  );

  assign enc_out = enc_dly ^ enc_on_q;

  // Output multiplexer: bypass, scrambler first, or encoder first.
  always_comb begin
    if (!cfg_enc_path)     out_d = sdata_in ^ scr_mask;
    else if (cfg_scr_first) out_d = enc_out;
    else                    out_d = enc_out ^ scr_mask;
  end

  always_ff @(posedge clk or negedge rst_n_i) begin
    if (!rst_n_i)  out_q <= 1'b0;
    else if (step) out_q <= out_d;
  end

  assign sdata_out = out_q;

  // R4
  enable_bound_chk: assert property (@(posedge clk) disable iff (!rst_n_i)
    !boundary |=> ($stable(scr_on_q) && $stable(enc_on_q)));
  // R9
  out_hold_chk: assert property (@(posedge clk) disable iff (!rst_n_i)
    !scr_step |=> $stable(sdata_out));
  // R2
  adv_hold_chk: assert property (@(posedge clk) disable iff (!rst_n_i)
    (cfg_adv_mode == MODE_OFF) |=> $stable(cnt_q));
  // R9
  strobe_nest_chk: assert property (@(posedge clk) disable iff (!rst_n_i)
    enc_step |-> scr_step);
endmodule

// File: tb/serial_coding_path_bench.sv
`timescale 1ns/100ps
module serial_coding_path_bench;
  logic clk = 1'b0;
  logic rst_n;
  logic sdata_in, data_en, pin_scr, pin_enc;
  logic [1:0] cfg_adv_mode, cfg_scr_mode, cfg_enc_mode;
  logic cfg_scr_first, cfg_enc_path;
  logic sdata_out, scr_step, enc_step;

  int total = 0;
  int fails = 0;

  always #2.5 clk = ~clk;

  serial_coding_path u_serial_coding_path (
    .clk(clk), .rst_n(rst_n), .sdata_in(sdata_in), .data_en(data_en),
    .pin_scr(pin_scr), .pin_enc(pin_enc), .cfg_adv_mode(cfg_adv_mode),
    .cfg_scr_mode(cfg_scr_mode), .cfg_enc_mode(cfg_enc_mode),
    .cfg_scr_first(cfg_scr_first), .cfg_enc_path(cfg_enc_path),
    .sdata_out(sdata_out), .scr_step(scr_step), .enc_step(enc_step)
  );

  // Bench model state
  logic       m_de, m_ps1s, m_ps2s, m_ps1e, m_ps2e;
  logic [2:0] m_cnt;
  logic       m_scr_e, m_enc_e, m_out;
  logic [6:0] m_lfsr;
  logic [7:0] m_q;

  function automatic logic res(input logic [1:0] m, input logic e);
    if (m == 2'b01) return 1'b0;
    if (m == 2'b11) return 1'b1;
    return e;
  endfunction

  task automatic chk(input logic act, input logic exp, input string tag);
    total++;
    if (act !== exp) begin
      fails++;
      $display("FAIL %s: actual %b expected %b (adv=%b scr=%b enc=%b first=%b path=%b) t=%0t",
               tag, act, exp, cfg_adv_mode, cfg_scr_mode, cfg_enc_mode,
               cfg_scr_first, cfg_enc_path, $time);
    end
  endtask

  task automatic model_reset();
    m_de = 0; m_ps1s = 0; m_ps2s = 0; m_ps1e = 0; m_ps2e = 0;
    m_cnt = 0; m_scr_e = 0; m_enc_e = 0; m_out = 0;
    m_lfsr = 7'h7F; m_q = 8'h00;
  endtask

  task automatic do_reset();
    cfg_adv_mode = 2'b01; sdata_in = 0; data_en = 0; pin_scr = 0; pin_enc = 0;
    rst_n = 0;
    repeat (3) @(negedge clk);
    rst_n = 1;
    repeat (4) @(negedge clk);
    model_reset();
    chk(sdata_out, 1'b0, "R1 reset output");
  endtask

  // One cycle: called at a negedge; drives inputs, checks strobes, advances model.
  task automatic cycle(input logic x, input logic de, input logic ps, input logic pe,
                       input string tag);
    logic st, s, eo, din, o;
    sdata_in = x; data_en = de; pin_scr = ps; pin_enc = pe;
    #1;
    st = res(cfg_adv_mode, m_de);
    chk(scr_step, st, "R9 scr_step");
    chk(enc_step, st & cfg_enc_path, "R9 enc_step");
    s   = m_scr_e & m_lfsr[6];
    eo  = m_q[7] ^ m_enc_e;
    din = cfg_scr_first ? (x ^ s) : x;
    if (!cfg_enc_path)      o = x ^ s;
    else if (cfg_scr_first) o = eo;
    else                    o = eo ^ s;
    if (st) begin
      m_out = o;
      if (cfg_enc_path) m_q = {m_q[6:0], din};
      m_lfsr = {m_lfsr[5:0], m_lfsr[6] ^ m_lfsr[5]};
      if (m_cnt == 3'd7) begin
        m_scr_e = res(cfg_scr_mode, m_ps2s);
        m_enc_e = res(cfg_enc_mode, m_ps2e);
      end
      m_cnt = m_cnt + 3'd1;
    end
    m_ps2s = m_ps1s; m_ps1s = ps;
    m_ps2e = m_ps1e; m_ps1e = pe;
    m_de = de;
    @(negedge clk);
    chk(sdata_out, m_out, tag);
  endtask

  initial begin
    repeat (200000) @(posedge clk);
    fails++; total++;
    $display("FAIL watchdog: actual timeout expected completion");
    $display("%0d/%0d checks passed", total - fails, total);
    $finish;
  end

  initial begin
    logic [1:0] modes [3];
    string tag;
    modes[0] = 2'b01; modes[1] = 2'b11; modes[2] = 2'b10;
    cfg_scr_mode = 2'b01; cfg_enc_mode = 2'b01;
    cfg_scr_first = 0; cfg_enc_path = 0;
    for (int a = 0; a < 3; a++)
      for (int sm = 0; sm < 3; sm++)
        for (int em = 0; em < 3; em++)
          for (int fo = 0; fo < 2; fo++)
            for (int pa = 0; pa < 2; pa++) begin
              cfg_scr_mode = modes[sm];
              cfg_enc_mode = modes[em];
              cfg_scr_first = fo[0];
              cfg_enc_path = pa[0];
              do_reset();
              cfg_adv_mode = modes[a];
              if (a == 0)          tag = "R2 hold";
              else if (sm == 2 || em == 2) tag = "R3 R4 pin";
              else if (pa == 0)    tag = (sm == 1) ? "R5 scramble" : "R8 bypass";
              else if (fo == 1)    tag = "R7 order";
              else                 tag = "R6 encoder";
              for (int c = 0; c < 44; c++) begin
                int v;
                v = (c + 1) * (a * 7 + sm * 3 + em * 5 + fo + pa * 11 + 13);
                cycle(v[2] ^ v[4] ^ v[0], (c % 3) != 0,
                      ((c / 5) % 2) == 1, ((c / 7) % 2) == 1, tag);
              end
            end
    $display("%0d/%0d checks passed", total - fails, total);
    $finish;
  end
endmodule